// File: doc/BRIEF.md
# Bidirectional Signed-Amount Barrel Shifter

This block shifts a data operand `a` by an amount `b` under a run-time mode select and presents the result on a registered output `y`. There are two kinds of mode. Four directional modes take an unsigned amount: logical left, arithmetic left (which is the same as logical left), logical right and arithmetic right. Two bidirectional modes take an amount whose sign picks the direction. A non-negative amount shifts right and a negative amount shifts left by its magnitude. The second bidirectional mode fills the vacated bit positions with a configurable fill bit instead of zero. This models extraction of a window from a wider word, in the way a part-select does.

The widths of `a`, `b` and `y` are parameters, and so are the signedness of `a` and `b`. Before any shift, `a` is widened to an internal width equal to the larger of the input and output widths. The widening is sign extension or zero extension, according to the signedness of `a`. The low `Y_W` bits of the shifted word form the result. An amount whose magnitude reaches the internal width saturates to all-fill bits and never wraps. The result is registered on the rising clock edge and cleared by a synchronous active-high reset.

Top module: `bsh_top`

## Requirements
- R1: While `rst` is high at a rising edge, `y` becomes all zeros at that edge, whatever the other inputs are.
- R2: `y` shows the result for the `a`, `b` and `mode` that were present at the previous rising edge. The latency is exactly one clock.
- R3: Mode codes 0 (logical left) and 1 (arithmetic left) give identical results. The extended `a` is shifted toward the MSB by `b` and zeros fill the low bits.
- R4: Mode code 2 (logical right) shifts the extended `a` toward the LSB by `b`, and zeros fill the top of the internal word.
- R5: Mode code 3 (arithmetic right) fills the vacated top bits with the MSB of `a` when `A_SGN` is nonzero, and with zeros when it is zero.
- R6: Before shifting, `a` is widened to max(`A_W`,`Y_W`) bits, by sign extension when `A_SGN` is nonzero and by zero extension otherwise. `y` is the low `Y_W` bits of the shifted word.
- R7: In mode code 4 (bidirectional), an amount that is non-negative, or any amount when `B_SGN` is zero, gives a logical right shift by `b`.
- R8: In mode code 4, an amount that is negative when `B_SGN` is nonzero gives a logical left shift by its magnitude. This includes the most negative value.
- R9: Mode code 5 (bidirectional with fill) picks the direction in the same way as code 4. Every vacated position on either side takes `FILL_BIT`.
- R10: A shift magnitude of at least max(`A_W`,`Y_W`) yields all-fill bits (zero, the sign of `a`, or `FILL_BIT`, depending on the mode) and does not wrap.
- R11: Mode codes 6 and 7 produce zero. When `DIR_EN` is zero, codes 0 to 3 also produce zero. The combination of a nonzero `B_SGN` with a nonzero `DIR_EN` is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| a | input | A_W | Data operand |
| b | input | B_W | Shift amount, two's complement when B_SGN is nonzero |
| mode | input | 3 | Operation select, codes 0 to 5 as in the requirements |
| y | output | Y_W | Registered shift result |

## Verification
Every combination of `a`, `b` and `mode` is applied to three configurations: a signed operand whose output is wider than it, an unsigned operand whose output is narrower than it, and a signed amount with the directional modes disabled. The first configuration separates sign fill from zero fill in arithmetic right shifts and the fill bit from zero in the fill variant. The narrow configuration shows whether bits above the output width are shifted down into view rather than lost. The signed-amount configuration separates left shifts from right shifts by the sign of `b`, and its most negative amount of eight exposes both magnitude overflow and saturation.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

  typedef enum logic [2:0] {
    BSH_SHL        = 3'd0,
    BSH_SSHL       = 3'd1,
    BSH_SHR        = 3'd2,
    BSH_SSHR       = 3'd3,
    BSH_BIDIR      = 3'd4,
    BSH_BIDIR_FILL = 3'd5
  } bsh_mode_e;

  function automatic int bsh_max(input int x, input int y);
    return (x > y) ? x : y;
  endfunction

endpackage

// File: rtl/bsh_extend.sv
module bsh_extend #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 8,
  parameter int SGN   = 1
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);

  localparam int PAD_W = OUT_W - IN_W;

  generate
    if (PAD_W == 0) begin : g_same
      assign dout = din;
    end else begin : g_pad
      logic top_bit;
      assign top_bit = (SGN != 0) ? din[IN_W-1] : 1'b0;
      assign dout    = {{PAD_W{top_bit}}, din};
    end
  endgenerate

endmodule

// File: rtl/bsh_amount.sv
module bsh_amount #(
  parameter int B_W   = 4,
  parameter int B_SGN = 0
) (
  input  logic [B_W-1:0] b,
  output logic [B_W-1:0] mag,
  output logic           neg
);

  localparam logic [B_W-1:0] ONE = {{(B_W-1){1'b0}}, 1'b1};

  assign neg = (B_SGN != 0) ? b[B_W-1] : 1'b0;
  // The magnitude of the most negative value equals its unsigned reading
  assign mag = neg ? ((~b) + ONE) : b;

endmodule

// File: rtl/bsh_barrel.sv
module bsh_barrel #(
  parameter int W    = 8,
  parameter int SW   = 4,
  parameter int LEFT = 0
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  input  logic          fill,
  output logic [W-1:0]  dout
);

  logic [W-1:0] stg [SW+1];

  assign stg[0] = din;

  generate
    for (genvar k = 0; k < SW; k++) begin : g_stage
      localparam int D = 2 ** k;
      if (D >= W) begin : g_sat
        assign stg[k+1] = amt[k] ? {W{fill}} : stg[k];
      end else if (LEFT != 0) begin : g_left
        assign stg[k+1] = amt[k] ? {stg[k][W-1-D:0], {D{fill}}} : stg[k];
      end else begin : g_right
        assign stg[k+1] = amt[k] ? {{D{fill}}, stg[k][W-1:D]} : stg[k];
      end
    end
  endgenerate

  assign dout = stg[SW];

endmodule

// File: rtl/bsh_top.sv
module bsh_top
  import bsh_pkg::*;
#(
  parameter int   A_W      = 8,
  parameter int   B_W      = 4,
  parameter int   Y_W      = 8,
  parameter int   A_SGN    = 1,
  parameter int   B_SGN    = 0,
  parameter int   DIR_EN   = 1,
  parameter logic FILL_BIT = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [A_W-1:0] a,
  input  logic [B_W-1:0] b,
  input  logic [2:0]     mode,
  output logic [Y_W-1:0] y
);

  localparam int IW = bsh_max(A_W, Y_W);

  // R11: directional modes need an unsigned amount
  generate
    if ((B_SGN != 0) && (DIR_EN != 0)) begin : g_bad_cfg
      $error("bsh_top: signed amount is illegal with directional modes enabled");
    end
  endgenerate

  logic [IW-1:0]  ext_a;
  logic [B_W-1:0] mag;
  logic           neg;
  logic [IW-1:0]  sh_l;
  logic [IW-1:0]  sh_r;
  logic           fill_l;
  logic           fill_r;
  logic [IW-1:0]  sel;
  logic           dir_ok;

  bsh_extend #(.IN_W(A_W), .OUT_W(IW), .SGN(A_SGN)) u_ext (
    .din  (a),
    .dout (ext_a)
  );

  bsh_amount #(.B_W(B_W), .B_SGN(B_SGN)) u_amt (
    .b   (b),
    .mag (mag),
    .neg (neg)
  );

  bsh_barrel #(.W(IW), .SW(B_W), .LEFT(1)) u_left (
    .din  (ext_a),
    .amt  (mag),
    .fill (fill_l),
    .dout (sh_l)
  );

  bsh_barrel #(.W(IW), .SW(B_W), .LEFT(0)) u_right (
    .din  (ext_a),
    .amt  (mag),
    .fill (fill_r),
    .dout (sh_r)
  );

  assign dir_ok = (DIR_EN != 0);

  always_comb begin
    fill_l = 1'b0;
    fill_r = 1'b0;
    if (mode == BSH_BIDIR_FILL) begin
      fill_l = FILL_BIT;
      fill_r = FILL_BIT;
    end else if (mode == BSH_SSHR) begin
      fill_r = (A_SGN != 0) ? ext_a[IW-1] : 1'b0;
    end
  end

  always_comb begin
    case (mode)
      BSH_SHL, BSH_SSHL:         sel = dir_ok ? sh_l : '0;
      BSH_SHR, BSH_SSHR:         sel = dir_ok ? sh_r : '0;
      BSH_BIDIR, BSH_BIDIR_FILL: sel = neg ? sh_l : sh_r;
      default:                   sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y <= '0;
    end else begin
      y <= sel[Y_W-1:0];
    end
  end

endmodule

// File: rtl/bsh_chk.sv
module bsh_chk
  import bsh_pkg::*;
#(
  parameter int   A_W      = 8,
  parameter int   B_W      = 4,
  parameter int   Y_W      = 8,
  parameter int   A_SGN    = 1,
  parameter int   B_SGN    = 0,
  parameter int   DIR_EN   = 1,
  parameter logic FILL_BIT = 1'b1
) (
  input logic           clk,
  input logic           rst,
  input logic [A_W-1:0] a,
  input logic [B_W-1:0] b,
  input logic [2:0]     mode,
  input logic [Y_W-1:0] y
);

  localparam int          IW   = bsh_max(A_W, Y_W);
  localparam logic [31:0] IW_U = 32'(IW);

  logic [31:0] b_u;
  logic        armed = 1'b0;

  assign b_u = 32'(b);

  always_ff @(posedge clk) armed <= 1'b1;

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!armed)
    rst |=> (y == '0)); // R1

  AST_LEFT_LSB_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((DIR_EN != 0) && ((mode == BSH_SHL) || (mode == BSH_SSHL)) && (b != '0))
    |=> (y[0] == 1'b0)); // R3

  AST_WIDE_RIGHT_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((DIR_EN != 0) && (mode == BSH_SHR) && (b_u >= IW_U)) |=> (y == '0)); // R10

  AST_ARITH_SIGN: assert property (@(posedge clk) disable iff (rst)
    ((DIR_EN != 0) && (A_SGN != 0) && (mode == BSH_SSHR) && (b_u >= IW_U))
    |=> (y == {Y_W{$past(a[A_W-1])}})); // R5

  AST_FILL_SAT: assert property (@(posedge clk) disable iff (rst)
    ((mode == BSH_BIDIR_FILL) && !((B_SGN != 0) && b[B_W-1]) && (b_u >= IW_U))
    |=> (y == {Y_W{FILL_BIT}})); // R9

  AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((mode > BSH_BIDIR_FILL) || ((DIR_EN == 0) && (mode < BSH_BIDIR)))
    |=> (y == '0)); // R11

endmodule

bind bsh_top bsh_chk #(
  .A_W(A_W), .B_W(B_W), .Y_W(Y_W), .A_SGN(A_SGN), .B_SGN(B_SGN),
  .DIR_EN(DIR_EN), .FILL_BIT(FILL_BIT)
) u_chk (
  .clk(clk), .rst(rst), .a(a), .b(b), .mode(mode), .y(y)
);

// File: tb/bsh_top_tb_top.sv
`timescale 1ns/1ps
module bsh_top_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] a   = '0;
  logic [2:0] b3  = '0;
  logic [3:0] b4  = '0;
  logic [2:0] mode = '0;
  logic [5:0] y_i;
  logic [5:0] y_s;
  logic [2:0] y_u;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  // signed operand, wide output, unsigned amount, all modes
  bsh_top #(.A_W(4), .B_W(3), .Y_W(6), .A_SGN(1), .B_SGN(0), .DIR_EN(1),
            .FILL_BIT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .a(a), .b(b3), .mode(mode), .y(y_i));

  // signed amount, directional modes disabled
  bsh_top #(.A_W(4), .B_W(4), .Y_W(6), .A_SGN(1), .B_SGN(1), .DIR_EN(0),
            .FILL_BIT(1'b1)) dut_s (
    .clk(clk), .rst(rst), .a(a), .b(b4), .mode(mode), .y(y_s));

  // unsigned operand, narrow output, fill bit zero
  bsh_top #(.A_W(4), .B_W(3), .Y_W(3), .A_SGN(0), .B_SGN(0), .DIR_EN(1),
            .FILL_BIT(1'b0)) dut_u (
    .clk(clk), .rst(rst), .a(a), .b(b3), .mode(mode), .y(y_u));

  logic [31:0] q_i[$];
  logic [31:0] q_s[$];
  logic [31:0] q_u[$];
  string       t_i[$];
  string       t_s[$];
  string       t_u[$];

  // Reference built from language shift operators
  function automatic logic [31:0] model(input int aw, input int bw, input int yw,
      input int asg, input int bsg, input int dir, input int fill,
      input logic [31:0] av, input logic [31:0] bv, input int md);
    int iw;
    logic [31:0] m_iw, ext, sx, res, fl;
    logic neg;
    int mag;
    iw   = (aw > yw) ? aw : yw;
    m_iw = (32'd1 << iw) - 32'd1;
    av   = av & ((32'd1 << aw) - 32'd1);
    bv   = bv & ((32'd1 << bw) - 32'd1);
    if (asg != 0 && av[aw-1]) ext = av | (m_iw & ~((32'd1 << aw) - 32'd1));
    else ext = av;
    sx  = (asg != 0 && ext[iw-1]) ? (ext | ~m_iw) : ext;
    neg = (bsg != 0) && bv[bw-1];
    mag = neg ? int'((32'd1 << bw) - bv) : int'(bv);
    res = '0;
    case (md)
      0, 1: res = (dir != 0) ? (ext << mag) : '0;
      2:    res = (dir != 0) ? (ext >> mag) : '0;
      3:    res = (dir != 0) ? 32'($signed(sx) >>> mag) : '0;
      4:    res = neg ? (ext << mag) : (ext >> mag);
      5: begin
        if (neg) begin
          fl  = (fill != 0) ? ((32'd1 << mag) - 32'd1) : '0;
          res = (ext << mag) | fl;
        end else begin
          fl  = (fill != 0) ? (m_iw & ~(m_iw >> mag)) : '0;
          res = (ext >> mag) | fl;
        end
      end
      default: res = '0;
    endcase
    return res & ((32'd1 << yw) - 32'd1);
  endfunction

  function automatic string tag(input int md, input bit neg, input bit sat,
                                input bit dis);
    string s;
    if (dis || md > 5)      s = "R11";
    else if (md <= 1)       s = "R3";
    else if (md == 2)       s = "R4";
    else if (md == 3)       s = "R5";
    else if (md == 4)       s = neg ? "R8" : "R7";
    else                    s = "R9";
    if (sat) s = {s, "/R10"};
    return {"R2/", s};
  endfunction

  task automatic drive(input logic [3:0] av, input logic [3:0] bv,
                       input logic [2:0] md);
    @(negedge clk);
    a    = av;
    b4   = bv;
    b3   = bv[2:0];
    mode = md;
    q_i.push_back(model(4, 3, 6, 1, 0, 1, 1, 32'(av), 32'(bv[2:0]), int'(md)));
    t_i.push_back(tag(int'(md), 1'b0, bv[2:0] >= 3'd6, 1'b0));
    q_s.push_back(model(4, 4, 6, 1, 1, 0, 1, 32'(av), 32'(bv), int'(md)));
    t_s.push_back(tag(int'(md), bv[3], bv == 4'd8, md < 3'd4));
    q_u.push_back(model(4, 3, 3, 0, 0, 1, 0, 32'(av), 32'(bv[2:0]), int'(md)));
    t_u.push_back({"R6/", tag(int'(md), 1'b0, bv[2:0] >= 3'd4, 1'b0)});
  endtask

  task automatic check(input string name, input string t,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (a=%0h b=%0h mode=%0d)",
               t, name, act, exp, a, b4, mode);
    end
  endtask

  // Monitor: results of the inputs driven before this edge
  always @(posedge clk) begin
    #2;
    if (q_i.size() > 0) begin
      check("dut_i", t_i.pop_front(), 32'(y_i), q_i.pop_front());
      check("dut_s", t_s.pop_front(), 32'(y_s), q_s.pop_front());
      check("dut_u", t_u.pop_front(), 32'(y_u), q_u.pop_front());
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    rst  = 1'b1;
    a    = 4'hF;
    b4   = 4'h1;
    b3   = 3'h1;
    mode = 3'd5;
    repeat (3) @(posedge clk);
    #2;
    // R1: nonzero inputs while in reset
    check("dut_i", "R1", 32'(y_i), 32'd0);
    check("dut_s", "R1", 32'(y_s), 32'd0);
    check("dut_u", "R1", 32'(y_u), 32'd0);
    @(negedge clk);
    rst = 1'b0;
    for (int m = 0; m < 8; m++) begin
      for (int bb = 0; bb < 16; bb++) begin
        for (int aa = 0; aa < 16; aa++) begin
          drive(4'(aa), 4'(bb), 3'(m));
        end
      end
    end
    // R1: reset in mid-stream clears an all-ones result
    drive(4'hF, 4'h0, 3'd4);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #2;
    check("dut_i", "R1", 32'(y_i), 32'd0);
    check("dut_u", "R1", 32'(y_u), 32'd0);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule